// File: doc/BRIEF.md
# Remote Memory Transfer Engine

This block moves a run of bytes between a host-facing data port and local packet memory under command control. Software loads a 16-bit starting address and a 16-bit byte count, one byte at a time, through a small register port, then writes a 3-bit command. A read command makes the engine fetch from memory and hold the next item ready on the host data port. A write command makes it store each item the host supplies. A command with its top bit set stops whatever is running.

The starting-address registers load the running address pointer directly. That pointer advances as the transfer proceeds, so after an abort it shows where the transfer stopped rather than where it began. A configuration register selects byte or 16-bit word transfers and enables the completion interrupt. When the last item has moved, a sticky completion flag is set. Software clears that flag through a status register.

Top module: `hostmem_dma`

## Requirements
- R1: After reset the engine is idle: `busy`, `hostRdValid`, `doneFlag` and `irq` are low, and `curAddr` and `byteCount` are zero.
- R2: A register write with `regSel` 0 or 1 loads the low or high byte of the address pointer (`curAddr`). A write with `regSel` 2 or 3 loads the low or high byte of `byteCount`.
- R3: Writing `regSel` 4 with command bits `regWrData[2:0]` equal to 000 or 011 is ignored. The engine stays idle, makes no memory access, and leaves `doneFlag`, `curAddr` and `byteCount` unchanged.
- R4: Command 001 starts a read. Each item is fetched from `memAddr` = `curAddr` and is then held on `hostRdData` with `hostRdValid` high, before the host asks for it. A one-cycle `hostRdStrobe` consumes the item, and the engine then fetches the next one. In byte mode `hostRdData` carries the byte in bits 7:0, and bits 15:8 are zero.
- R5: Command 010 starts a write. Each `hostWrStrobe` cycle drives `memWrEn` high in that same cycle, with `memAddr` = `curAddr` and `memWrData` = `hostWrData`.
- R6: Each transfer advances `curAddr` by 1 in byte mode or by 2 in word mode, modulo 2^16. It lowers `byteCount` by the same step and stops at zero, so an odd count in word mode rounds up to one extra word.
- R7: When the last item has been consumed by the host (read) or written (write), `doneFlag` sets and `busy` falls. A read or write command given with `byteCount` zero sets `doneFlag` at once and makes no memory access.
- R8: Any command with bit 2 set stops the engine in the next cycle: `busy` and `hostRdValid` go low and no further memory access occurs. `curAddr` and `byteCount` keep their progressed values, and `doneFlag` is not set.
- R9: `irq` is high exactly when `doneFlag` is set and the interrupt-enable bit (`regSel` 5, bit 1) is set. Writing `regSel` 6 with bit 0 set clears `doneFlag`.
- R10: Setting bit 0 of `regSel` 5 selects word mode. In word mode `memWrWord` is high and a read returns both memory bytes: {byte at address+1, byte at address}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regSel | input | 3 | Register select |
| regWrData | input | 8 | Register write data |
| hostRdStrobe | input | 1 | Host consumes the held read item |
| hostRdData | output | 16 | Prefetched read item |
| hostRdValid | output | 1 | Read item is held and ready |
| hostWrStrobe | input | 1 | Host supplies a write item |
| hostWrData | input | 16 | Write item from host |
| memAddr | output | 16 | Memory byte address |
| memRdEn | output | 1 | Memory read request; data expected the next cycle |
| memRdData | input | 16 | Memory read data {addr+1, addr} |
| memWrEn | output | 1 | Memory write enable |
| memWrWord | output | 1 | Write both bytes (word mode) |
| memWrData | output | 16 | Memory write data |
| curAddr | output | 16 | Running address pointer |
| byteCount | output | 16 | Remaining byte count |
| busy | output | 1 | Transfer in progress |
| doneFlag | output | 1 | Sticky completion flag |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest situation to reach is an abort that arrives while a prefetched read item is already held. At that point the pointer and the count have moved one item past what the host has taken. The bench consumes two bytes of a six-byte read and waits until the third is held. It then issues an abort and checks that the pointer and the count show three bytes gone. A second abort lands in the middle of a write. A host strobe that follows that abort must not reach memory. Word-mode runs across the top of the address space and an odd word count cover the wrap and the rounding.

// File: rtl/hostmem_dma_pkg.sv
package hostmem_dma_pkg;

  localparam int SEL_W = 3;

  localparam logic [SEL_W-1:0] SEL_ADDR_LO = 3'd0;
  localparam logic [SEL_W-1:0] SEL_ADDR_HI = 3'd1;
  localparam logic [SEL_W-1:0] SEL_CNT_LO  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_CNT_HI  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_CMD     = 3'd4;
  localparam logic [SEL_W-1:0] SEL_CFG     = 3'd5;
  localparam logic [SEL_W-1:0] SEL_STAT    = 3'd6;

  localparam logic [2:0] CMD_READ  = 3'b001;
  localparam logic [2:0] CMD_WRITE = 3'b010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_HOLD,
    ST_WRITE
  } dma_state_e;

  typedef struct packed {
    logic loadAddrLo;
    logic loadAddrHi;
    logic loadCntLo;
    logic loadCntHi;
    logic loadCfg;
    logic clearDone;
    logic setDone;
    logic advance;
    logic capture;
  } dp_strobe_t;

endpackage

// File: rtl/hostmem_dma_ctrl.sv
module hostmem_dma_ctrl
  import hostmem_dma_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [SEL_W-1:0] regSel,
  input  logic [2:0]       cmdBits,
  input  logic             clrBit,
  input  logic             hostRdStrobe,
  input  logic             hostWrStrobe,
  input  logic             countZero,
  input  logic             countLast,
  output dp_strobe_t       strb,
  output logic             memRdEn,
  output logic             memWrEn,
  output logic             hostRdValid,
  output logic             busy
);

  dma_state_e state, nextState;
  logic cmdWr, abortReq, startRead, startWrite;

  assign cmdWr      = regWr && (regSel == SEL_CMD);
  assign abortReq   = cmdWr && cmdBits[2];
  assign startRead  = cmdWr && (cmdBits == CMD_READ);
  assign startWrite = cmdWr && (cmdBits == CMD_WRITE);

  always_comb begin
    strb            = '0;
    nextState       = state;
    memRdEn         = 1'b0;
    memWrEn         = 1'b0;
    strb.loadAddrLo = regWr && (regSel == SEL_ADDR_LO);
    strb.loadAddrHi = regWr && (regSel == SEL_ADDR_HI);
    strb.loadCntLo  = regWr && (regSel == SEL_CNT_LO);
    strb.loadCntHi  = regWr && (regSel == SEL_CNT_HI);
    strb.loadCfg    = regWr && (regSel == SEL_CFG);
    strb.clearDone  = regWr && (regSel == SEL_STAT) && clrBit;
    if (abortReq) begin
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startRead || startWrite) begin
            if (countZero) strb.setDone = 1'b1;
            else nextState = startRead ? ST_FETCH : ST_WRITE;
          end
        end
        ST_FETCH: begin
          memRdEn      = 1'b1;
          strb.advance = 1'b1;
          nextState    = ST_WAIT;
        end
        ST_WAIT: begin
          strb.capture = 1'b1;
          nextState    = ST_HOLD;
        end
        ST_HOLD: begin
          if (hostRdStrobe) begin
            if (countZero) begin
              strb.setDone = 1'b1;
              nextState    = ST_IDLE;
            end else begin
              nextState = ST_FETCH;
            end
          end
        end
        ST_WRITE: begin
          if (hostWrStrobe) begin
            memWrEn      = 1'b1;
            strb.advance = 1'b1;
            if (countLast) begin
              strb.setDone = 1'b1;
              nextState    = ST_IDLE;
            end
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign hostRdValid = (state == ST_HOLD);
  assign busy        = (state != ST_IDLE);

  // R8
  abort_stops_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> (!busy && !hostRdValid && !memRdEn && !memWrEn));

  // R3
  ignored_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && cmdWr && !cmdBits[2] && cmdBits[0] == cmdBits[1]) |=> !busy);

  // R4
  prefetch_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && !abortReq) |=> ##1 (hostRdValid || !busy));

  // R5
  mem_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn));

endmodule

// File: rtl/hostmem_dma_dp.sv
module hostmem_dma_dp
  import hostmem_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dp_strobe_t          strb,
  input  logic [BYTE_W-1:0]   regWrData,
  input  logic [2*BYTE_W-1:0] memRdData,
  output logic [ADDR_W-1:0]   curAddr,
  output logic [CNT_W-1:0]    byteCount,
  output logic [2*BYTE_W-1:0] dataOut,
  output logic                wordMode,
  output logic                doneFlag,
  output logic                irqOut,
  output logic                countZero,
  output logic                countLast
);

  localparam int WORD_W = 2 * BYTE_W;

  logic              irqEn;
  logic [ADDR_W-1:0] addrStep;
  logic [CNT_W-1:0]  cntStep;

  assign addrStep  = wordMode ? ADDR_W'(2) : ADDR_W'(1);
  assign cntStep   = wordMode ? CNT_W'(2) : CNT_W'(1);
  assign countZero = (byteCount == '0);
  assign countLast = (byteCount <= cntStep);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      byteCount <= '0;
      dataOut   <= '0;
      wordMode  <= 1'b0;
      irqEn     <= 1'b0;
      doneFlag  <= 1'b0;
    end else begin
      if (strb.loadAddrLo) curAddr[BYTE_W-1:0]       <= regWrData;
      if (strb.loadAddrHi) curAddr[ADDR_W-1:BYTE_W]  <= regWrData[ADDR_W-BYTE_W-1:0];
      if (strb.loadCntLo)  byteCount[BYTE_W-1:0]     <= regWrData;
      if (strb.loadCntHi)  byteCount[CNT_W-1:BYTE_W] <= regWrData[CNT_W-BYTE_W-1:0];
      if (strb.loadCfg) begin
        wordMode <= regWrData[0];
        irqEn    <= regWrData[1];
      end
      if (strb.advance) begin
        curAddr   <= curAddr + addrStep;
        byteCount <= countLast ? '0 : byteCount - cntStep;
      end
      if (strb.capture)
        dataOut <= wordMode ? memRdData : {{BYTE_W{1'b0}}, memRdData[BYTE_W-1:0]};
      if (strb.setDone)        doneFlag <= 1'b1;
      else if (strb.clearDone) doneFlag <= 1'b0;
    end
  end

  assign irqOut = doneFlag && irqEn;

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> (curAddr == $past(curAddr) + $past(addrStep)));

  // R6
  count_falls_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.loadCntLo && !strb.loadCntHi) |=> (byteCount < $past(byteCount)));

  // R7
  done_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setDone |=> doneFlag);

  // R10
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !wordMode) |=> (dataOut[WORD_W-1:BYTE_W] == '0));

endmodule

// File: rtl/hostmem_dma.sv
module hostmem_dma
  import hostmem_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic [SEL_W-1:0]    regSel,
  input  logic [BYTE_W-1:0]   regWrData,
  input  logic                hostRdStrobe,
  output logic [2*BYTE_W-1:0] hostRdData,
  output logic                hostRdValid,
  input  logic                hostWrStrobe,
  input  logic [2*BYTE_W-1:0] hostWrData,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memRdEn,
  input  logic [2*BYTE_W-1:0] memRdData,
  output logic                memWrEn,
  output logic                memWrWord,
  output logic [2*BYTE_W-1:0] memWrData,
  output logic [ADDR_W-1:0]   curAddr,
  output logic [CNT_W-1:0]    byteCount,
  output logic                busy,
  output logic                doneFlag,
  output logic                irq
);

  dp_strobe_t strb;
  logic       countZero, countLast, wordMode;

  hostmem_dma_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .regWr        (regWr),
    .regSel       (regSel),
    .cmdBits      (regWrData[2:0]),
    .clrBit       (regWrData[0]),
    .hostRdStrobe (hostRdStrobe),
    .hostWrStrobe (hostWrStrobe),
    .countZero    (countZero),
    .countLast    (countLast),
    .strb         (strb),
    .memRdEn      (memRdEn),
    .memWrEn      (memWrEn),
    .hostRdValid  (hostRdValid),
    .busy         (busy)
  );

  hostmem_dma_dp #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .BYTE_W (BYTE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regWrData (regWrData),
    .memRdData (memRdData),
    .curAddr   (curAddr),
    .byteCount (byteCount),
    .dataOut   (hostRdData),
    .wordMode  (wordMode),
    .doneFlag  (doneFlag),
    .irqOut    (irq),
    .countZero (countZero),
    .countLast (countLast)
  );

  assign memAddr   = curAddr;
  assign memWrData = hostWrData;
  assign memWrWord = wordMode;

endmodule

// File: tb/hostmem_dma_tb.sv
`timescale 1ns/100ps
module hostmem_dma_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regSel = '0;
  logic [7:0]  regWrData = '0;
  logic        hostRdStrobe = 1'b0;
  logic [15:0] hostRdData;
  logic        hostRdValid;
  logic        hostWrStrobe = 1'b0;
  logic [15:0] hostWrData = '0;
  logic [15:0] memAddr;
  logic        memRdEn;
  logic [15:0] memRdData = '0;
  logic        memWrEn;
  logic        memWrWord;
  logic [15:0] memWrData;
  logic [15:0] curAddr;
  logic [15:0] byteCount;
  logic        busy;
  logic        doneFlag;
  logic        irq;

  int checks = 0;
  int fails = 0;
  int rdAcc = 0;
  int wrAcc = 0;

  logic [7:0]  mem    [256];
  logic [7:0]  golden [256];
  logic [15:0] rdQ [$];
  logic [32:0] wrQ [$];

  always #2.5 clk = ~clk;

  hostmem_dma u_dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .regWrData(regWrData),
    .hostRdStrobe(hostRdStrobe), .hostRdData(hostRdData), .hostRdValid(hostRdValid),
    .hostWrStrobe(hostWrStrobe), .hostWrData(hostWrData), .memAddr(memAddr),
    .memRdEn(memRdEn), .memRdData(memRdData), .memWrEn(memWrEn), .memWrWord(memWrWord),
    .memWrData(memWrData), .curAddr(curAddr), .byteCount(byteCount), .busy(busy),
    .doneFlag(doneFlag), .irq(irq)
  );

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (memRdEn) memRdData <= {mem[memAddr[7:0] + 8'd1], mem[memAddr[7:0]]};
    if (memWrEn) begin
      mem[memAddr[7:0]] <= memWrData[7:0];
      if (memWrWord) mem[memAddr[7:0] + 8'd1] <= memWrData[15:8];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: scoreboard compare between the driving negedge and the next posedge
  initial begin
    logic [15:0] actData;
    forever begin
      @(negedge clk);
      #1;
      if (memRdEn) rdAcc++;
      if (hostRdValid && hostRdStrobe) begin
        if (rdQ.size() == 0) check("R4 unexpected read item", 32'd1, 32'd0);
        else check("R4 read data", {16'h0, hostRdData}, {16'h0, rdQ.pop_front()});
      end
      if (memWrEn) begin
        wrAcc++;
        actData = memWrWord ? memWrData : {8'h00, memWrData[7:0]};
        if (wrQ.size() == 0) check("R5 unexpected memory write", 32'd1, 32'd0);
        else check("R5 write addr/data/word", {memWrWord, memAddr, actData}, {31'h0, 1'b0} | wrQ.pop_front());
      end
    end
  end

  task automatic regWrite(input logic [2:0] sel, input logic [7:0] data);
    @(negedge clk);
    regWr = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic setup(input logic [15:0] addr, input logic [15:0] cnt, input logic word);
    regWrite(3'd6, 8'h01);
    regWrite(3'd5, {7'h0, word});
    regWrite(3'd0, addr[7:0]);
    regWrite(3'd1, addr[15:8]);
    regWrite(3'd2, cnt[7:0]);
    regWrite(3'd3, cnt[15:8]);
  endtask

  task automatic doRead(input logic [15:0] addr, input logic [15:0] cnt, input logic word);
    int n;
    int got;
    logic [15:0] a;
    n = word ? (int'(cnt) + 1) / 2 : int'(cnt);
    setup(addr, cnt, word);
    for (int i = 0; i < n; i++) begin
      a = addr + 16'(word ? 2 * i : i);
      rdQ.push_back(word ? {golden[a[7:0] + 8'd1], golden[a[7:0]]} : {8'h00, golden[a[7:0]]});
    end
    regWrite(3'd4, 8'h01);
    got = 0;
    while (got < n) begin
      @(negedge clk);
      if (hostRdValid) begin hostRdStrobe = 1'b1; got++; end
      else hostRdStrobe = 1'b0;
    end
    @(negedge clk);
    hostRdStrobe = 1'b0;
    check("R7 read busy low at end", {31'h0, busy}, 32'd0);
    check("R7 read done set", {31'h0, doneFlag}, 32'd1);
    check("R4 all read items seen", rdQ.size(), 32'd0);
    check("R6 read final address", {16'h0, curAddr}, {16'h0, addr + 16'(word ? 2 * n : n)});
    check("R6 read final count", {16'h0, byteCount}, 32'd0);
  endtask

  task automatic doWrite(input logic [15:0] addr, input logic [15:0] cnt, input logic word, input logic [7:0] seed);
    int n;
    logic [15:0] a;
    logic [15:0] d;
    n = word ? (int'(cnt) + 1) / 2 : int'(cnt);
    setup(addr, cnt, word);
    regWrite(3'd4, 8'h02);
    for (int i = 0; i < n; i++) begin
      a = addr + 16'(word ? 2 * i : i);
      d = {seed ^ 8'(i * 3), seed + 8'(i * 11)};
      wrQ.push_back({word, a, word ? d : {8'h00, d[7:0]}});
      golden[a[7:0]] = d[7:0];
      if (word) golden[a[7:0] + 8'd1] = d[15:8];
      @(negedge clk);
      hostWrStrobe = 1'b1; hostWrData = d;
    end
    @(negedge clk);
    hostWrStrobe = 1'b0;
    check("R7 write busy low at end", {31'h0, busy}, 32'd0);
    check("R7 write done set", {31'h0, doneFlag}, 32'd1);
    check("R5 all writes seen", wrQ.size(), 32'd0);
    check("R6 write final address", {16'h0, curAddr}, {16'h0, addr + 16'(word ? 2 * n : n)});
    check("R6 write final count", {16'h0, byteCount}, 32'd0);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int rdBefore;
    int wrBefore;
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 8'(i * 7 + 3);
      golden[i] = 8'(i * 7 + 3);
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", {31'h0, busy}, 32'd0);
    check("R1 hostRdValid", {31'h0, hostRdValid}, 32'd0);
    check("R1 doneFlag", {31'h0, doneFlag}, 32'd0);
    check("R1 irq", {31'h0, irq}, 32'd0);
    check("R1 curAddr", {16'h0, curAddr}, 32'd0);
    check("R1 byteCount", {16'h0, byteCount}, 32'd0);

    // R2 register loads
    regWrite(3'd0, 8'h34);
    regWrite(3'd1, 8'h12);
    regWrite(3'd2, 8'h05);
    regWrite(3'd3, 8'hAB);
    check("R2 address halves", {16'h0, curAddr}, 32'h1234);
    check("R2 count halves", {16'h0, byteCount}, 32'hAB05);

    // R4 byte read, R10 word read, R6 odd word count
    doRead(16'h0010, 16'd5, 1'b0);
    doRead(16'h0020, 16'd4, 1'b1);
    doRead(16'h0040, 16'd3, 1'b1);

    // R5 byte write, then R6 word write across the top of the address space
    doWrite(16'h0080, 16'd3, 1'b0, 8'h5C);
    doWrite(16'hFFFE, 16'd3, 1'b1, 8'hA1);
    doRead(16'h0080, 16'd3, 1'b0);
    doRead(16'hFFFE, 16'd4, 1'b1);

    // R7 zero count completes at once
    setup(16'h0030, 16'd0, 1'b0);
    rdBefore = rdAcc;
    regWrite(3'd4, 8'h01);
    check("R7 zero count done", {31'h0, doneFlag}, 32'd1);
    check("R7 zero count not busy", {31'h0, busy}, 32'd0);
    repeat (3) @(negedge clk);
    check("R7 zero count no fetch", rdAcc, rdBefore);

    // R3 ignored commands 000 and 011
    setup(16'h0050, 16'd4, 1'b0);
    rdBefore = rdAcc; wrBefore = wrAcc;
    regWrite(3'd4, 8'h00);
    check("R3 cmd 000 stays idle", {31'h0, busy}, 32'd0);
    regWrite(3'd4, 8'h03);
    check("R3 cmd 011 stays idle", {31'h0, busy}, 32'd0);
    repeat (3) @(negedge clk);
    check("R3 no done", {31'h0, doneFlag}, 32'd0);
    check("R3 no memory access", rdAcc + wrAcc, rdBefore + wrBefore);
    check("R3 address kept", {16'h0, curAddr}, 32'h0050);
    check("R3 count kept", {16'h0, byteCount}, 32'd4);

    // R8 abort with a prefetched item held
    setup(16'h0060, 16'd6, 1'b0);
    rdQ.push_back({8'h00, golden[8'h60]});
    rdQ.push_back({8'h00, golden[8'h61]});
    regWrite(3'd4, 8'h01);
    begin
      int got;
      got = 0;
      while (got < 2) begin
        @(negedge clk);
        if (hostRdValid) begin hostRdStrobe = 1'b1; got++; end
        else hostRdStrobe = 1'b0;
      end
      @(negedge clk);
      hostRdStrobe = 1'b0;
      while (!hostRdValid) @(negedge clk);
    end
    regWrite(3'd4, 8'h04);
    check("R8 read abort busy low", {31'h0, busy}, 32'd0);
    check("R8 read abort valid low", {31'h0, hostRdValid}, 32'd0);
    check("R8 read abort address not restored", {16'h0, curAddr}, 32'h0063);
    check("R8 read abort count kept", {16'h0, byteCount}, 32'd3);
    check("R8 read abort no done", {31'h0, doneFlag}, 32'd0);

    // R8 abort in the middle of a write
    setup(16'h0090, 16'd4, 1'b0);
    regWrite(3'd4, 8'h02);
    wrQ.push_back({1'b0, 16'h0090, 16'h0077});
    golden[8'h90] = 8'h77;
    @(negedge clk);
    hostWrStrobe = 1'b1; hostWrData = 16'h0077;
    @(negedge clk);
    hostWrStrobe = 1'b0;
    regWrite(3'd4, 8'h05);
    wrBefore = wrAcc;
    @(negedge clk);
    hostWrStrobe = 1'b1; hostWrData = 16'h00EE;
    @(negedge clk);
    hostWrStrobe = 1'b0;
    check("R8 write abort no further write", wrAcc, wrBefore);
    check("R8 write abort address", {16'h0, curAddr}, 32'h0091);
    check("R8 write abort count", {16'h0, byteCount}, 32'd3);
    check("R8 write abort no done", {31'h0, doneFlag}, 32'd0);

    // R9 interrupt gating and clear
    setup(16'h0000, 16'd0, 1'b0);
    regWrite(3'd4, 8'h02);
    check("R9 done set for irq test", {31'h0, doneFlag}, 32'd1);
    check("R9 irq masked", {31'h0, irq}, 32'd0);
    regWrite(3'd5, 8'h02);
    check("R9 irq enabled", {31'h0, irq}, 32'd1);
    regWrite(3'd6, 8'h00);
    check("R9 clear needs bit 0", {31'h0, doneFlag}, 32'd1);
    regWrite(3'd6, 8'h01);
    check("R9 done cleared", {31'h0, doneFlag}, 32'd0);
    check("R9 irq drops", {31'h0, irq}, 32'd0);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule